// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dial Generator

This block turns decimal digits into loop-disconnect dialing pulses, the signalling that rotary telephone dials use. A controller offers one digit at a time over a valid/ready handshake. For each digit the block waits out a pre-digit pause, then interrupts the line loop once per count by driving the active-low dial output low for a break interval. Each break is followed by a make interval. After the last make the block holds an inter-digit pause, and only then accepts the next digit. A mute output, also active low, stays asserted for the whole sequence so the earpiece is silenced while the line is being broken.

Two selects set the timing. The rate select picks 10 or 20 pulses per second. The ratio select picks a make:break split of 40:60 or 33.3:66.7. Both selects are sampled when a digit is accepted. All times are counted in base units of `TICK_CLKS` clock cycles, and one unit is nominally 1/600 s. A 10 pps period is therefore 60 units and a 20 pps period is 30 units. An abort input stops any dialing in progress on the next clock edge.

Top module: `pulse_dialer`

## Requirements
- R1: `in_ready` is high exactly when the block is idle and `abort` is low. A digit is taken on a rising edge where both `in_valid` and `in_ready` are high, and `busy` is high from the following cycle.
- R2: An accepted digit code d from 1 to 9 produces exactly d break intervals, and the code 0 produces exactly 10 break intervals. During a break `dial_n` is low.
- R3: Digit codes 10 to 15 are consumed by the handshake but ignored. They produce no break, `busy` stays low and `in_ready` stays high.
- R4: The pre-digit pause is the interval from acceptance to the first break. It lasts as long as one make interval of the selected rate and ratio, with `dial_n` high.
- R5: With `ratio_short` = 0 a break lasts 60% of the pulse period and a make 40%. With `ratio_short` = 1 a break lasts two thirds of the period and a make one third.
- R6: The pulse period is 60 base units with `rate_fast` = 0 (10 pps) and 30 base units with `rate_fast` = 1 (20 pps). One base unit is `TICK_CLKS` clock cycles.
- R7: After the last make interval, an inter-digit pause of 480 units at 10 pps or 300 units at 20 pps elapses before `busy` falls and the block becomes ready again.
- R8: `mute_n` is low and `busy` is high from the cycle after acceptance until the end of the inter-digit pause. Otherwise `mute_n` is high and `busy` is low.
- R9: When `abort` is high at a clock edge, `dial_n` and `mute_n` are high and `busy` is low from the next cycle. While `abort` is high no digit is accepted.
- R10: The rate and ratio selects are captured at acceptance. Changing them during a digit does not alter that digit's timing.
- R11: After reset `dial_n` and `mute_n` are high, `busy` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_digit | input | 4 | Digit code; 0 means ten pulses |
| in_valid | input | 1 | A digit is offered |
| in_ready | output | 1 | The block can take a digit |
| rate_fast | input | 1 | 0: 10 pps, 1: 20 pps |
| ratio_short | input | 1 | 0: 40:60 make:break, 1: 33.3:66.7 |
| abort | input | 1 | Stop dialing at once |
| dial_n | output | 1 | Dial pulse, low during a break |
| mute_n | output | 1 | Mute, low while dialing |
| busy | output | 1 | A digit is being dialed |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `in_digit`, `rate_fast` and `ratio_short` matter only on the edge where a digit is taken, and that `TICK_CLKS` is at least one. The bench changes every input at the falling edge and samples at the falling edge. It moves the selects in the middle of a digit on purpose, to show that only the captured values count. Abort is held for a full cycle, both during a break and together with a pending digit.

// File: rtl/dial_pkg.sv
// Shared types and timing constants for the pulse dialer.
// Assumes one base unit is 1/600 s; all durations are in base units.
package dial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BRK,
        ST_MAK,
        ST_IDP
    } dial_state_e;

    localparam int unsigned PERIOD_SLOW_U = 60;   // 10 pps
    localparam int unsigned PERIOD_FAST_U = 30;   // 20 pps
    localparam int unsigned IDP_SLOW_U    = 480;  // 800 ms
    localparam int unsigned IDP_FAST_U    = 300;  // 500 ms
    localparam int unsigned MAX_PULSES    = 10;

endpackage

// File: rtl/dial_timing.sv
// Converts the rate and ratio selects into break, make and pause lengths
// in clock cycles. Purely combinational; assumes TICK_CLKS >= 1.
module dial_timing
    import dial_pkg::*;
#(
    parameter int unsigned TICK_CLKS = 1667,
    parameter int unsigned CW        = 20
) (
    input  logic          fast,
    input  logic          short_make,
    output logic [CW-1:0] brk_clks,
    output logic [CW-1:0] mak_clks,
    output logic [CW-1:0] idp_clks
);

    int unsigned period_u;
    int unsigned brk_u;

    // Derive unit lengths from the period, then scale to clocks.
    always_comb begin
        period_u = fast ? PERIOD_FAST_U : PERIOD_SLOW_U;
        brk_u    = short_make ? (period_u * 2) / 3 : (period_u * 6) / 10;
        brk_clks = CW'(brk_u * TICK_CLKS);
        mak_clks = CW'((period_u - brk_u) * TICK_CLKS);
        idp_clks = CW'((fast ? IDP_FAST_U : IDP_SLOW_U) * TICK_CLKS);
    end

endmodule

// File: rtl/dial_pulse_count.sv
// Holds the number of breaks still to be produced for the current digit.
// Assumes load is only asserted for codes 0..9; code 0 loads ten.
module dial_pulse_count
    import dial_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       load,
    input  logic [3:0] digit,
    input  logic       step,
    output logic       last
);

    logic [3:0] remaining;

    // Load on acceptance, count down after each completed pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= (digit == 4'd0) ? 4'(MAX_PULSES) : digit;
        end else if (step && remaining != '0) begin
            remaining <= remaining - 4'd1;
        end
    end

    assign last = (remaining == 4'd1);

    // R2: the pulse count never exceeds ten
    a_r2_remaining_range: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= 4'(MAX_PULSES));

endmodule

// File: rtl/dial_seq.sv
// State machine for one digit: pre-digit pause, break/make pairs and the
// inter-digit pause. A single down-counter times every interval.
// Assumes the length inputs are stable while a state is timed.
module dial_seq
    import dial_pkg::*;
#(
    parameter int unsigned CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [CW-1:0] brk_clks,
    input  logic [CW-1:0] mak_clks,
    input  logic [CW-1:0] idp_clks,
    input  logic          last_pulse,
    output dial_state_e   state,
    output logic          pulse_step
);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire     = (cnt == '0);
    assign pulse_step = (state == ST_MAK) && expire && !last_pulse;

    // Advance through the phases of a digit; abort returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PRE;
                    cnt   <= mak_clks - CW'(1);
                end
                ST_PRE: if (expire) begin
                    state <= ST_BRK;
                    cnt   <= brk_clks - CW'(1);
                end else cnt <= cnt - CW'(1);
                ST_BRK: if (expire) begin
                    state <= ST_MAK;
                    cnt   <= mak_clks - CW'(1);
                end else cnt <= cnt - CW'(1);
                ST_MAK: if (expire) begin
                    state <= last_pulse ? ST_IDP : ST_BRK;
                    cnt   <= last_pulse ? idp_clks - CW'(1) : brk_clks - CW'(1);
                end else cnt <= cnt - CW'(1);
                ST_IDP: if (expire) begin
                    state <= ST_IDLE;
                end else cnt <= cnt - CW'(1);
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: abort always returns the sequencer to idle
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> state == ST_IDLE);

    // R4: a started digit begins with the pre-digit pause
    a_r4_pre_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !abort) |=> state == ST_PRE);

    // R7: a break is never followed directly by the inter-digit pause
    a_r7_idp_after_make: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDP && $past(state) != ST_IDP) |-> $past(state) == ST_MAK);

endmodule

// File: rtl/pulse_dialer.sv
// Loop-disconnect pulse dialer top: handshake, select capture, timing,
// pulse counting and the active-low dial and mute outputs.
// Assumes inputs synchronous to clk; TICK_CLKS clocks form one 1/600 s unit.
module pulse_dialer
    import dial_pkg::*;
#(
    parameter int unsigned TICK_CLKS = 1667
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] in_digit,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       rate_fast,
    input  logic       ratio_short,
    input  logic       abort,
    output logic       dial_n,
    output logic       mute_n,
    output logic       busy
);

    localparam int unsigned CW = $clog2(IDP_SLOW_U * TICK_CLKS + 1);

    dial_state_e   state;
    logic          accept;
    logic          digit_ok;
    logic          start;
    logic          fast_q;
    logic          short_q;
    logic          fast_sel;
    logic          short_sel;
    logic          last_pulse;
    logic          pulse_step;
    logic [CW-1:0] brk_clks;
    logic [CW-1:0] mak_clks;
    logic [CW-1:0] idp_clks;

    assign in_ready  = (state == ST_IDLE) && !abort;
    assign accept    = in_valid && in_ready;
    assign digit_ok  = (in_digit <= 4'd9);
    assign start     = accept && digit_ok;
    assign busy      = (state != ST_IDLE);
    assign dial_n    = (state != ST_BRK);
    assign mute_n    = !busy;
    assign fast_sel  = busy ? fast_q  : rate_fast;
    assign short_sel = busy ? short_q : ratio_short;

    // Capture the selects when a digit is started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q  <= 1'b0;
            short_q <= 1'b0;
        end else if (start) begin
            fast_q  <= rate_fast;
            short_q <= ratio_short;
        end
    end

    dial_timing #(.TICK_CLKS(TICK_CLKS), .CW(CW)) u_timing (
        .fast       (fast_sel),
        .short_make (short_sel),
        .brk_clks   (brk_clks),
        .mak_clks   (mak_clks),
        .idp_clks   (idp_clks)
    );

    dial_pulse_count u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (abort),
        .load  (start),
        .digit (in_digit),
        .step  (pulse_step),
        .last  (last_pulse)
    );

    dial_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (abort),
        .start      (start),
        .brk_clks   (brk_clks),
        .mak_clks   (mak_clks),
        .idp_clks   (idp_clks),
        .last_pulse (last_pulse),
        .state      (state),
        .pulse_step (pulse_step)
    );

    // R1: a valid digit handshake makes the block busy next cycle
    a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3: an out-of-range code leaves the block idle
    a_r3_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !digit_ok) |=> !busy);

    // R8: the line is only broken while a digit is in progress
    a_r8_break_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !dial_n |-> (busy && !mute_n));

    // R10: captured selects hold for the whole digit
    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(fast_q) && $stable(short_q)));

    // R9: abort releases the line and the mute on the next cycle
    a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (dial_n && mute_n && !busy));

endmodule

// File: tb/tb_pulse_dialer.sv
// Self-checking bench: a vector table of digits and selects measured at the
// ports, then directed tests for reset, bad codes, select changes and abort.
module tb_pulse_dialer;

    localparam int unsigned TICK = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_digit = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       rate_fast = 1'b0;
    logic       ratio_short = 1'b0;
    logic       abort = 1'b0;
    logic       dial_n;
    logic       mute_n;
    logic       busy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    pulse_dialer #(.TICK_CLKS(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .in_digit(in_digit), .in_valid(in_valid),
        .in_ready(in_ready), .rate_fast(rate_fast), .ratio_short(ratio_short),
        .abort(abort), .dial_n(dial_n), .mute_n(mute_n), .busy(busy)
    );

    // Vector: [5:2] digit, [1] rate_fast, [0] ratio_short
    localparam logic [5:0] VEC [8] = '{
        {4'd1, 1'b0, 1'b0}, {4'd3, 1'b0, 1'b1}, {4'd0, 1'b1, 1'b0},
        {4'd9, 1'b1, 1'b1}, {4'd2, 1'b1, 1'b0}, {4'd0, 1'b0, 1'b1},
        {4'd7, 1'b0, 1'b0}, {4'd5, 1'b1, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: counts as a failed check and ends the run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !timed_out) begin
            timed_out = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Offer one digit, optionally flip the selects mid-digit, measure the ports.
    task automatic dial(input logic [3:0] d, input logic fast, input logic shortm,
                        input bit flip);
        int period, brk, mak, idp, n;
        int pre, breaks, cur_low, cur_high, bad_brk, bad_mak, mute_bad;
        bit seen_low;
        period = fast ? 30 : 60;
        brk    = shortm ? (period * 2) / 3 : (period * 6) / 10;
        mak    = (period - brk) * TICK;
        brk    = brk * TICK;
        idp    = (fast ? 300 : 480) * TICK;
        n      = (d == 0) ? 10 : d;
        @(negedge clk);
        check("R1 ready when idle", in_ready, 1);
        in_digit = d; rate_fast = fast; ratio_short = shortm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (flip) begin rate_fast = !fast; ratio_short = !shortm; end
        check("R1 busy after accept", busy, 1);
        pre = 0; breaks = 0; cur_low = 0; cur_high = 0;
        bad_brk = 0; bad_mak = 0; mute_bad = 0; seen_low = 1'b0;
        while (busy) begin
            if (mute_n !== 1'b0) mute_bad++;
            if (!dial_n) begin
                if (!seen_low) pre = cur_high;
                else if (cur_high > 0 && cur_high != mak) bad_mak++;
                if (cur_low == 0) breaks++;
                cur_high = 0; cur_low++; seen_low = 1'b1;
            end else begin
                if (cur_low > 0 && cur_low != brk) bad_brk++;
                cur_low = 0; cur_high++;
            end
            @(negedge clk);
        end
        check("R4 pre-digit pause", pre, mak);
        check("R2 break count", breaks, n);
        check("R5/R6 break length mismatches", bad_brk, 0);
        check("R5/R6 make length mismatches", bad_mak, 0);
        check("R7 last make plus inter-digit pause", cur_high, mak + idp);
        check("R8 mute low while busy", mute_bad, 0);
        check("R8 mute released after digit", mute_n, 1);
        if (flip) check("R10 selects captured at acceptance", pre, mak);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset dial_n", dial_n, 1);
        check("R11 reset mute_n", mute_n, 1);
        check("R11 reset busy", busy, 0);
        check("R11 reset in_ready", in_ready, 1);

        for (int i = 0; i < 8; i++) begin
            dial(VEC[i][5:2], VEC[i][1], VEC[i][0], 1'b0);
        end

        // R3: out-of-range codes are consumed and ignored
        for (int c = 10; c < 16; c++) begin
            int low_seen;
            int busy_seen;
            low_seen = 0;
            busy_seen = 0;
            in_digit = 4'(c); in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            for (int k = 0; k < 40; k++) begin
                if (!dial_n) low_seen++;
                if (busy) busy_seen++;
                @(negedge clk);
            end
            check("R3 no break for bad code", low_seen, 0);
            check("R3 not busy for bad code", busy_seen, 0);
            check("R3 ready after bad code", in_ready, 1);
        end

        // R10: selects changed right after acceptance do not matter
        dial(4'd4, 1'b0, 1'b0, 1'b1);
        dial(4'd2, 1'b1, 1'b1, 1'b1);

        // R9: abort in the middle of a break
        in_digit = 4'd5; rate_fast = 1'b1; ratio_short = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (dial_n) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        check("R9 abort releases dial_n", dial_n, 1);
        check("R9 abort releases mute_n", mute_n, 1);
        check("R9 abort clears busy", busy, 0);
        check("R9 not ready during abort", in_ready, 0);
        in_valid = 1'b1; in_digit = 4'd3;
        @(negedge clk);
        check("R9 no accept during abort", busy, 0);
        in_valid = 1'b0; abort = 1'b0;
        @(negedge clk);
        check("R9 idle after abort", busy, 0);
        dial(4'd3, 1'b1, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule